// File: doc/BRIEF.md
# Partial-Write Read-Modify-Write Sequencer

This block sits between a user command port and a memory controller core on a path protected by an error-correcting code. Each accepted command carries a 3-bit code, an address and a per-byte write mask. The block sorts it into a full-word write, a read, or a byte-granular write, and issues simple command and address pulses toward the core.

A full-word write and a read each go straight through as one command pulse. A byte write never goes out as a plain write. The block first issues a read of the target word, tagged as part of a read-modify-write. It then waits for the corrected word to come back from the decode pipeline and keeps it in a small holding register. For one cycle it presents that word to the merge stage, together with the user's new data and mask, and the byte-merged result. Finally it issues the write-back to the same address.

The error-correction arithmetic and the DRAM timing belong to other blocks. Read data comes back in issue order. The block therefore counts the plain reads still in flight, so that their returns are not mistaken for the read-modify-write word.

Top module: `rmw_seq`

## Requirements
- R1: An accepted code 3'b000 (full write) produces, on the next cycle, a one-cycle `mc_cmd_valid_o` with `mc_cmd_rd_o`=0, `mc_rmw_o`=0 and `mc_addr_o` equal to the command address.
- R2: An accepted code 3'b001 (read) produces, on the next cycle, a one-cycle command pulse with `mc_cmd_rd_o`=1, `mc_rmw_o`=0 and the command address. The mask is not used.
- R3: An accepted code 3'b011 (byte write) produces, on the next cycle, a read pulse with `mc_rmw_o`=1, and never a plain write. `cmd_ready_o` stays low from the cycle after acceptance up to the cycle in which the write-back is issued.
- R4: One cycle after the read-modify-write word is sampled on `rd_valid_i`, `mrg_valid_o` is high for exactly one cycle. `mrg_data_o` byte k then equals the new data byte k where mask bit k is 1, and the held corrected byte k where mask bit k is 0. Bit k covers data bits 8k+7..8k.
- R5: The cycle after `mrg_valid_o`, a write pulse with `mc_rmw_o`=1 is issued to the byte write's address, and `cmd_ready_o` returns high.
- R6: Byte-write data is taken from `wdata_i` in the acceptance cycle or the cycle after it, whichever first has `wdata_valid_i`. If neither has it, `late_data_o` pulses two cycles after acceptance and the new data is taken as zero.
- R7: A full write whose mask is not all ones raises `proto_err_o` on the next cycle and is still issued as a full write.
- R8: Any other code (010, 1xx) issues no command and raises `bad_cmd_o` on the next cycle.
- R9: Returns for plain reads accepted before a byte write are consumed first, in order. They never reach the holding register or raise `mrg_valid_o`.
- R10: When MAX_RD plain reads are outstanding, `cmd_ready_o` is low. Each return lowers the count by one and reopens the port.
- R11: During and right after reset, `cmd_ready_o` is 1 and every command and flag output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | User command valid |
| cmd_ready_o | output | 1 | Command port ready |
| cmd_code_i | input | 3 | Command code |
| cmd_addr_i | input | AW | Command address |
| cmd_mask_i | input | DW/8 | Byte mask, 1 = byte written |
| wdata_valid_i | input | 1 | Write data valid |
| wdata_i | input | DW | Write data |
| rd_valid_i | input | 1 | Corrected read data valid (in issue order) |
| rd_data_i | input | DW | Corrected read data |
| mc_cmd_valid_o | output | 1 | Command pulse to core |
| mc_cmd_rd_o | output | 1 | 1 = read, 0 = write |
| mc_rmw_o | output | 1 | Command belongs to a read-modify-write |
| mc_addr_o | output | AW | Command address to core |
| mrg_valid_o | output | 1 | Merge stage operands valid |
| mrg_old_o | output | DW | Held corrected word |
| mrg_new_o | output | DW | User write data |
| mrg_mask_o | output | DW/8 | User byte mask |
| mrg_data_o | output | DW | Byte-merged word |
| proto_err_o | output | 1 | Full write with a partial mask |
| bad_cmd_o | output | 1 | Unsupported code seen |
| late_data_o | output | 1 | Byte-write data missed its window |

## Verification
Command pulses and the protocol and unsupported-code flags are due one cycle after the acceptance edge. The late-data flag is due two cycles after it. Merge operands appear one cycle after the read word is sampled, and the write-back one cycle after the merge. Inputs change on the falling edge, and each check samples on the falling edge that follows exactly the number of rising edges listed above. Ready is also sampled in every cycle of a byte write's wait, to confirm that the port stays closed.

// File: rtl/rmw_pkg.sv
package rmw_pkg;
  localparam logic [2:0] CODE_WR = 3'b000;
  localparam logic [2:0] CODE_RD = 3'b001;
  localparam logic [2:0] CODE_BW = 3'b011;

  typedef enum logic [1:0] {K_WR, K_RD, K_BW, K_BAD} cmd_kind_e;
  typedef enum logic [1:0] {S_IDLE, S_RD_WAIT, S_MERGE} seq_state_e;
endpackage

// File: rtl/rmw_cmd_dec.sv
module rmw_cmd_dec
  import rmw_pkg::*;
#(
  parameter int MW = 4
) (
  input  logic [2:0]    code_i,
  input  logic [MW-1:0] mask_i,
  output cmd_kind_e     kind_o,
  output logic          mask_full_o
);
  always_comb begin
    unique case (code_i)
      CODE_WR: kind_o = K_WR;
      CODE_RD: kind_o = K_RD;
      CODE_BW: kind_o = K_BW;
      default: kind_o = K_BAD;
    endcase
  end

  assign mask_full_o = &mask_i;
endmodule

// File: rtl/rmw_rd_track.sv
module rmw_rd_track #(
  parameter int MAX_RD = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inc_i,
  input  logic ret_i,
  output logic pend_o,
  output logic full_o
);
  localparam int CW = $clog2(MAX_RD + 1);

  logic [CW-1:0] cnt_q;
  logic          dec;

  // returns only retire plain reads while any are in flight
  assign dec    = ret_i && (cnt_q != '0);
  assign pend_o = (cnt_q != '0);
  assign full_o = (cnt_q == CW'(MAX_RD));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (inc_i && !dec) cnt_q <= cnt_q + 1'b1;
    else if (dec && !inc_i) cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/rmw_hold_buf.sv
module rmw_hold_buf #(
  parameter int DW = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            old_ld_i,
  input  logic [DW-1:0]   old_i,
  input  logic            new_ld_i,
  input  logic [DW-1:0]   new_i,
  input  logic            mask_ld_i,
  input  logic [DW/8-1:0] mask_i,
  output logic [DW-1:0]   old_o,
  output logic [DW-1:0]   new_o,
  output logic [DW/8-1:0] mask_o,
  output logic [DW-1:0]   merged_o
);
  localparam int MW = DW / 8;

  logic [DW-1:0] old_q, new_q;
  logic [MW-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      old_q  <= '0;
      new_q  <= '0;
      mask_q <= '0;
    end else begin
      if (old_ld_i)  old_q  <= old_i;
      if (new_ld_i)  new_q  <= new_i;
      if (mask_ld_i) mask_q <= mask_i;
    end
  end

  for (genvar b = 0; b < MW; b++) begin : g_byte
    assign merged_o[8*b +: 8] = mask_q[b] ? new_q[8*b +: 8] : old_q[8*b +: 8];
  end

  assign old_o  = old_q;
  assign new_o  = new_q;
  assign mask_o = mask_q;
endmodule

// File: rtl/rmw_seq.sv
module rmw_seq
  import rmw_pkg::*;
#(
  parameter int DW     = 32,
  parameter int AW     = 16,
  parameter int MAX_RD = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cmd_valid_i,
  output logic            cmd_ready_o,
  input  logic [2:0]      cmd_code_i,
  input  logic [AW-1:0]   cmd_addr_i,
  input  logic [DW/8-1:0] cmd_mask_i,
  input  logic            wdata_valid_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic            rd_valid_i,
  input  logic [DW-1:0]   rd_data_i,
  output logic            mc_cmd_valid_o,
  output logic            mc_cmd_rd_o,
  output logic            mc_rmw_o,
  output logic [AW-1:0]   mc_addr_o,
  output logic            mrg_valid_o,
  output logic [DW-1:0]   mrg_old_o,
  output logic [DW-1:0]   mrg_new_o,
  output logic [DW/8-1:0] mrg_mask_o,
  output logic [DW-1:0]   mrg_data_o,
  output logic            proto_err_o,
  output logic            bad_cmd_o,
  output logic            late_data_o
);
  localparam int MW = DW / 8;

  seq_state_e    state_q;
  cmd_kind_e     kind;
  logic          mask_full;
  logic          acc, bw_acc, rd_acc;
  logic          pend, trk_full, rmw_cap;
  logic          first_q, have_q;
  logic          new_ld;
  logic [DW-1:0] new_val;
  logic [AW-1:0] addr_q;
  logic          mc_v_q, mc_rd_q, mc_rmw_q;
  logic [AW-1:0] mc_addr_q;
  logic          perr_q, bad_q, late_q;

  rmw_cmd_dec #(.MW(MW)) u_dec (
    .code_i      (cmd_code_i),
    .mask_i      (cmd_mask_i),
    .kind_o      (kind),
    .mask_full_o (mask_full)
  );

  assign cmd_ready_o = (state_q == S_IDLE) && !trk_full;
  assign acc         = cmd_valid_i && cmd_ready_o;
  assign bw_acc      = acc && (kind == K_BW);
  assign rd_acc      = acc && (kind == K_RD);

  rmw_rd_track #(.MAX_RD(MAX_RD)) u_trk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (rd_acc),
    .ret_i  (rd_valid_i),
    .pend_o (pend),
    .full_o (trk_full)
  );

  // the byte-write word is the first return once older plain reads drain
  assign rmw_cap = (state_q == S_RD_WAIT) && rd_valid_i && !pend;

  // new data: acceptance cycle, else the following cycle, else zero
  assign new_ld  = bw_acc || (first_q && !have_q && wdata_valid_i);
  assign new_val = wdata_valid_i ? wdata_i : '0;

  rmw_hold_buf #(.DW(DW)) u_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .old_ld_i  (rmw_cap),
    .old_i     (rd_data_i),
    .new_ld_i  (new_ld),
    .new_i     (new_val),
    .mask_ld_i (bw_acc),
    .mask_i    (cmd_mask_i),
    .old_o     (mrg_old_o),
    .new_o     (mrg_new_o),
    .mask_o    (mrg_mask_o),
    .merged_o  (mrg_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      addr_q  <= '0;
      first_q <= 1'b0;
      have_q  <= 1'b0;
    end else begin
      first_q <= bw_acc;
      if (bw_acc) begin
        have_q <= wdata_valid_i;
        addr_q <= cmd_addr_i;
      end
      unique case (state_q)
        S_IDLE:    if (bw_acc) state_q <= S_RD_WAIT;
        S_RD_WAIT: if (rmw_cap) state_q <= S_MERGE;
        S_MERGE:   state_q <= S_IDLE;
        default:   state_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mc_v_q    <= 1'b0;
      mc_rd_q   <= 1'b0;
      mc_rmw_q  <= 1'b0;
      mc_addr_q <= '0;
      perr_q    <= 1'b0;
      bad_q     <= 1'b0;
      late_q    <= 1'b0;
    end else begin
      mc_v_q   <= 1'b0;
      mc_rd_q  <= 1'b0;
      mc_rmw_q <= 1'b0;
      perr_q   <= acc && (kind == K_WR) && !mask_full;
      bad_q    <= acc && (kind == K_BAD);
      late_q   <= first_q && !have_q && !wdata_valid_i;
      if (state_q == S_MERGE) begin
        mc_v_q    <= 1'b1;
        mc_rmw_q  <= 1'b1;
        mc_addr_q <= addr_q;
      end else if (acc && (kind != K_BAD)) begin
        mc_v_q    <= 1'b1;
        mc_rd_q   <= (kind != K_WR);
        mc_rmw_q  <= (kind == K_BW);
        mc_addr_q <= cmd_addr_i;
      end
    end
  end

  assign mrg_valid_o    = (state_q == S_MERGE);
  assign mc_cmd_valid_o = mc_v_q;
  assign mc_cmd_rd_o    = mc_rd_q;
  assign mc_rmw_o       = mc_rmw_q;
  assign mc_addr_o      = mc_addr_q;
  assign proto_err_o    = perr_q;
  assign bad_cmd_o      = bad_q;
  assign late_data_o    = late_q;
endmodule

// File: rtl/rmw_seq_chk.sv
module rmw_seq_chk #(
  parameter int MW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cmd_valid_i,
  input logic          cmd_ready_o,
  input logic [2:0]    cmd_code_i,
  input logic [MW-1:0] cmd_mask_i,
  input logic          rd_valid_i,
  input logic          mc_cmd_valid_o,
  input logic          mc_cmd_rd_o,
  input logic          mc_rmw_o,
  input logic          mrg_valid_o,
  input logic          proto_err_o,
  input logic          bad_cmd_o
);
  logic acc;
  assign acc = cmd_valid_i && cmd_ready_o;

  p_wr_issue_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && cmd_code_i == 3'b000) |=> (mc_cmd_valid_o && !mc_cmd_rd_o && !mc_rmw_o));

  p_rd_issue_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && cmd_code_i == 3'b001) |=> (mc_cmd_valid_o && mc_cmd_rd_o && !mc_rmw_o));

  p_bw_read_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && cmd_code_i == 3'b011) |=> (mc_cmd_valid_o && mc_cmd_rd_o && mc_rmw_o && !cmd_ready_o));

  p_merge_src_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mrg_valid_o |-> ($past(rd_valid_i) && !cmd_ready_o));

  p_merge_once_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mrg_valid_o |=> !mrg_valid_o);

  p_writeback_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mrg_valid_o |=> (mc_cmd_valid_o && !mc_cmd_rd_o && mc_rmw_o));

  p_mask_err_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && cmd_code_i == 3'b000 && !(&cmd_mask_i)) |=> (proto_err_o && mc_cmd_valid_o));

  p_bad_code_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && cmd_code_i != 3'b000 && cmd_code_i != 3'b001 && cmd_code_i != 3'b011)
      |=> (bad_cmd_o && !mc_cmd_valid_o));
endmodule

bind rmw_seq rmw_seq_chk #(.MW(DW/8)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .cmd_valid_i    (cmd_valid_i),
  .cmd_ready_o    (cmd_ready_o),
  .cmd_code_i     (cmd_code_i),
  .cmd_mask_i     (cmd_mask_i),
  .rd_valid_i     (rd_valid_i),
  .mc_cmd_valid_o (mc_cmd_valid_o),
  .mc_cmd_rd_o    (mc_cmd_rd_o),
  .mc_rmw_o       (mc_rmw_o),
  .mrg_valid_o    (mrg_valid_o),
  .proto_err_o    (proto_err_o),
  .bad_cmd_o      (bad_cmd_o)
);

// File: tb/rmw_seq_bench.sv
`timescale 1ns/1ps
module rmw_seq_bench;
  localparam int DW = 32;
  localparam int AW = 16;
  localparam int MW = DW / 8;
  localparam int MAX_RD = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [2:0]    cmd_code = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic [MW-1:0] cmd_mask = '0;
  logic          wdata_valid = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic          rd_valid = 1'b0;
  logic [DW-1:0] rd_data = '0;
  logic          mc_v, mc_rd, mc_rmw;
  logic [AW-1:0] mc_addr;
  logic          mrg_v;
  logic [DW-1:0] mrg_old, mrg_new, mrg_data;
  logic [MW-1:0] mrg_mask;
  logic          perr, bad, late;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  rmw_seq #(.DW(DW), .AW(AW), .MAX_RD(MAX_RD)) u_rmw_seq (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .cmd_code_i(cmd_code), .cmd_addr_i(cmd_addr), .cmd_mask_i(cmd_mask),
    .wdata_valid_i(wdata_valid), .wdata_i(wdata),
    .rd_valid_i(rd_valid), .rd_data_i(rd_data),
    .mc_cmd_valid_o(mc_v), .mc_cmd_rd_o(mc_rd), .mc_rmw_o(mc_rmw), .mc_addr_o(mc_addr),
    .mrg_valid_o(mrg_v), .mrg_old_o(mrg_old), .mrg_new_o(mrg_new),
    .mrg_mask_o(mrg_mask), .mrg_data_o(mrg_data),
    .proto_err_o(perr), .bad_cmd_o(bad), .late_data_o(late)
  );

  typedef struct packed {
    logic [2:0]    code;
    logic [MW-1:0] mask;
    logic [AW-1:0] addr;
    logic          v;
    logic          rd;
    logic          err;
    logic          bad;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{3'b000, 4'hF, 16'h0010, 1'b1, 1'b0, 1'b0, 1'b0},  // R1
    '{3'b000, 4'h6, 16'h0020, 1'b1, 1'b0, 1'b1, 1'b0},  // R7
    '{3'b001, 4'hF, 16'h0030, 1'b1, 1'b1, 1'b0, 1'b0},  // R2
    '{3'b010, 4'hF, 16'h0040, 1'b0, 1'b0, 1'b0, 1'b1},  // R8
    '{3'b111, 4'h0, 16'h0050, 1'b0, 1'b0, 1'b0, 1'b1},  // R8
    '{3'b001, 4'h0, 16'h0060, 1'b1, 1'b1, 1'b0, 1'b0}   // R2
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] o, input logic [DW-1:0] n,
                                          input logic [MW-1:0] m);
    logic [DW-1:0] r;
    for (int b = 0; b < MW; b++) r[8*b +: 8] = m[b] ? n[8*b +: 8] : o[8*b +: 8];
    return r;
  endfunction

  task automatic drive(input logic [2:0] c, input logic [MW-1:0] m, input logic [AW-1:0] a,
                       input logic wv, input logic [DW-1:0] wd);
    cmd_valid = 1'b1; cmd_code = c; cmd_mask = m; cmd_addr = a;
    wdata_valid = wv; wdata = wd;
  endtask

  task automatic ret(input logic [DW-1:0] d);
    rd_valid = 1'b1; rd_data = d;
    @(negedge clk);
    rd_valid = 1'b0;
  endtask

  // byte write from accept to write-back; returns after write-back check
  task automatic byte_write(input string tag, input logic [AW-1:0] a, input logic [MW-1:0] m,
                            input logic [DW-1:0] nd, input logic [DW-1:0] od);
    @(negedge clk);
    chk({tag, " R3 rd issued"}, {mc_v, mc_rd, mc_rmw, mc_addr}, {3'b111, a});
    chk({tag, " R3 ready low"}, cmd_ready, 1'b0);
    cmd_valid = 1'b0; wdata_valid = 1'b0;
    @(negedge clk);
    chk({tag, " R3 still waiting"}, {cmd_ready, mrg_v}, 2'b00);
    ret(od);
    chk({tag, " R4 merge"}, {mrg_v, mrg_data}, {1'b1, merge(od, nd, m)});
    chk({tag, " R3 ready low at merge"}, cmd_ready, 1'b0);
    @(negedge clk);
    chk({tag, " R5 write-back"}, {mc_v, mc_rd, mc_rmw, mc_addr}, {3'b101, a});
    chk({tag, " R5 ready back"}, {cmd_ready, mrg_v}, 2'b10);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R11 reset state
    repeat (3) @(negedge clk);
    chk("R11 reset outputs", {cmd_ready, mc_v, mrg_v, perr, bad, late}, 6'b100000);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 after reset", {cmd_ready, mc_v, mrg_v, perr, bad, late}, 6'b100000);

    // table of single-cycle commands: R1 R2 R7 R8
    for (int i = 0; i < 6; i++) begin
      drive(VEC[i].code, VEC[i].mask, VEC[i].addr, 1'b0, '0);
      @(negedge clk);
      cmd_valid = 1'b0;
      chk($sformatf("R1/R2/R7/R8 vec%0d pulse", i), {mc_v, mc_rd, mc_rmw},
          {VEC[i].v, VEC[i].rd, 1'b0});
      if (VEC[i].v) chk($sformatf("R1/R2 vec%0d addr", i), mc_addr, VEC[i].addr);
      chk($sformatf("R7/R8 vec%0d flags", i), {perr, bad}, {VEC[i].err, VEC[i].bad});
    end
    ret(32'h0); ret(32'h0);  // drain the two table reads

    // R3 R4 R5 R6: data with the command
    drive(3'b011, 4'b0101, 16'h0100, 1'b1, 32'hA1B2C3D4);
    byte_write("A", 16'h0100, 4'b0101, 32'hA1B2C3D4, 32'h11223344);

    // R6: data missing in both cycles -> late flag, zero data
    drive(3'b011, 4'b1001, 16'h0110, 1'b0, '0);
    @(negedge clk);
    cmd_valid = 1'b0;
    @(negedge clk);
    chk("R6 late flag", late, 1'b1);
    ret(32'hFFFFFFFF);
    chk("R6 late data zero in merge", {mrg_v, mrg_data}, {1'b1, 32'h00FFFF00});
    @(negedge clk);
    chk("R5 late write-back", {mc_v, mc_rd, mc_rmw, mc_addr}, {3'b101, 16'h0110});

    // R6: data one cycle after acceptance
    drive(3'b011, 4'b0011, 16'h0120, 1'b0, '0);
    @(negedge clk);
    cmd_valid = 1'b0; wdata_valid = 1'b1; wdata = 32'hCAFEBABE;
    @(negedge clk);
    wdata_valid = 1'b0;
    chk("R6 no late flag", late, 1'b0);
    ret(32'h0);
    chk("R6 next-cycle data merged", {mrg_v, mrg_data}, {1'b1, 32'h0000BABE});
    @(negedge clk);

    // R9: an older plain read returns first
    drive(3'b001, 4'hF, 16'h0200, 1'b0, '0);
    @(negedge clk);
    drive(3'b011, 4'b1100, 16'h0210, 1'b1, 32'h55667788);
    @(negedge clk);
    cmd_valid = 1'b0; wdata_valid = 1'b0;
    chk("R9 rmw read issued", {mc_v, mc_rd, mc_rmw}, 3'b111);
    ret(32'hDEADBEEF);
    chk("R9 plain return not merged", mrg_v, 1'b0);
    ret(32'h01020304);
    chk("R9 rmw word merged", {mrg_v, mrg_data}, {1'b1, 32'h55660304});
    @(negedge clk);

    // R10: outstanding read limit
    for (int k = 0; k < MAX_RD; k++) begin
      drive(3'b001, 4'hF, AW'(16'h0300 + k), 1'b0, '0);
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    chk("R10 ready low at limit", cmd_ready, 1'b0);
    ret(32'h0);
    chk("R10 ready after one return", cmd_ready, 1'b1);
    for (int k = 1; k < MAX_RD; k++) ret(32'h0);
    chk("R10 idle after drain", {cmd_ready, mrg_v, mc_v}, 3'b100);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule